// File: doc/BRIEF.md
# Board Interrupt and Control Register Block

This block is a memory-mapped peripheral on a simple 32-bit register bus. The bus has an address, a write strobe, write data and combinational read data. The block gathers sixteen level-sensitive interrupt lines that are synchronous to the bus clock. A line that is high while its enable bit is set latches into a pending word. The block drives one registered summary interrupt, which is high whenever an enabled pending bit exists. Software reads and writes the enable and pending words directly. Writing the pending word replaces its contents, so the same write can set bits and clear bits.

Beside the interrupt logic there are eight plain 32-bit words for the board's LEDs, switches and miscellaneous control. There are also two card-socket status words. Each socket word holds a ready flag and an active-low card-present flag. That flag follows a dedicated interrupt line: line 9 for socket 0 and line 13 for socket 1. Software may change only the five low control bits of a socket word.

Top module: `brd_ctl_regs`

## Requirements
- R1: A synchronous active-high reset sets both socket words to 0x0000_0420, with bit 10 ready and bit 5 card-absent set. It clears every other register and drives the summary interrupt low.
- R2: The words at offsets 0x10, 0x14, 0x40, 0x60, 0x80, 0x84, 0x88 and 0x90 store all 32 written bits and read them back unchanged.
- R3: A read from any other offset returns zero. A write to any other offset changes no register.
- R4: A write to the enable word at offset 0xC0 stores the written value ANDed with 0x000F_EEFF.
- R5: A write to the pending word at offset 0xD0 stores the written value ANDed with 0x000F_EEFF. This lets software both set and clear pending bits.
- R6: Each line is sampled into a level register on every clock. A sampled high level with the matching enable bit set sets the pending bit on the following edge. A low level or a cleared enable bit never clears a pending bit.
- R7: When a latch from a line and a bus write to the pending word fall on the same edge, the pending word takes the written value.
- R8: After every edge the summary interrupt equals the OR-reduction of pending AND enable, as held in those registers.
- R9: Bit 5 of socket word 0 (offset 0xE0) is the inverse of the sampled level of line 9. Bit 5 of socket word 1 (offset 0xE4) is the inverse of the sampled level of line 13. Each updates one edge after the sample.
- R10: A write to a socket word replaces only bits 4:0. Bits 31:5 keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_in | input | 16 | Level interrupt lines, synchronous to clk |
| irq_out | output | 1 | Registered summary interrupt |

## Verification
The bench targets several corner cases, each with a typical wrong behaviour:
- Enable bits 8 and 12: a design that applied no write mask would let those lines raise the summary.
- A line that falls after latching: a design that tracked the level instead of latching it would lose the pending bit.
- A pending write on the same edge as a latch: the wrong priority would leave a bit set that software had just cleared.
- A socket write of all ones: a design with too wide a write field would corrupt the ready flag or the card-absent flag.
- Card-absent flags under line toggles: a polarity error would report a card in the empty socket.

Random traffic to mapped and unmapped offsets is compared against a bench model on every cycle.

// File: rtl/brd_regs_pkg.sv
package brd_regs_pkg;

    localparam int DW       = 32;
    localparam int NIRQ     = 16;
    localparam int NPLAIN   = 8;
    localparam int SOCK_WRB = 5;
    localparam int CD_BIT   = 5;

    localparam logic [DW-1:0] IRQ_WMASK = 32'h000F_EEFF;
    localparam logic [DW-1:0] SOCK_RST  = 32'h0000_0420;

    localparam logic [7:0] OFS_MASK  = 8'hC0;
    localparam logic [7:0] OFS_PEND  = 8'hD0;
    localparam logic [7:0] OFS_SOCK0 = 8'hE0;
    localparam logic [7:0] OFS_SOCK1 = 8'hE4;

    localparam logic [7:0] PLAIN_OFS [NPLAIN] =
        '{8'h10, 8'h14, 8'h40, 8'h60, 8'h80, 8'h84, 8'h88, 8'h90};

    typedef struct packed {
        logic [NIRQ-1:0] level;
        logic [DW-1:0]   mask;
        logic [DW-1:0]   pend;
        logic            irq;
    } irq_state_t;

endpackage

// File: rtl/brd_irq_unit.sv
module brd_irq_unit
    import brd_regs_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NIRQ-1:0] irq_in,
    input  logic            wr_mask,
    input  logic            wr_pend,
    input  logic [DW-1:0]   wdata,
    output logic [NIRQ-1:0] level_q,
    output logic [DW-1:0]   mask_q,
    output logic [DW-1:0]   pend_q,
    output logic            irq_q
);
    localparam int PADW = DW - NIRQ;

    irq_state_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.level = irq_in;
        // a sampled high level on an enabled line sets pending; nothing here clears it
        s_d.pend  = s_q.pend | ({{PADW{1'b0}}, s_q.level} & s_q.mask);
        // a bus write overrides any same-edge latch
        if (wr_pend) s_d.pend = wdata & IRQ_WMASK;
        if (wr_mask) s_d.mask = wdata & IRQ_WMASK;
        s_d.irq   = |(s_d.pend & s_d.mask);
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign level_q = s_q.level;
    assign mask_q  = s_q.mask;
    assign pend_q  = s_q.pend;
    assign irq_q   = s_q.irq;
endmodule

// File: rtl/brd_sock_reg.sv
module brd_sock_reg
    import brd_regs_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                line_lvl,
    input  logic                wr,
    input  logic [SOCK_WRB-1:0] wdata,
    output logic [DW-1:0]       q
);
    logic [DW-1:0] d, r_q;

    always_comb begin
        d         = r_q;
        d[CD_BIT] = ~line_lvl;
        if (wr) d[SOCK_WRB-1:0] = wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= SOCK_RST;
        else     r_q <= d;
    end

    assign q = r_q;
endmodule

// File: rtl/brd_plain_regs.sv
module brd_plain_regs
    import brd_regs_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    output logic              hit
);
    logic [DW-1:0]     regs_d [NPLAIN];
    logic [DW-1:0]     regs_q [NPLAIN];
    logic [NPLAIN-1:0] sel;

    for (genvar i = 0; i < NPLAIN; i++) begin : g_dec
        assign sel[i] = (addr == ADDR_W'(PLAIN_OFS[i]));
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NPLAIN; i++) begin
            regs_d[i] = (we && sel[i]) ? wdata : regs_q[i];
            if (sel[i]) rdata = rdata | regs_q[i];
        end
    end

    for (genvar i = 0; i < NPLAIN; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) regs_q[i] <= '0;
            else     regs_q[i] <= regs_d[i];
        end
    end

    assign hit = |sel;
endmodule

// File: rtl/brd_ctl_regs.sv
module brd_ctl_regs
    import brd_regs_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int CD0_LINE = 9,
    parameter int CD1_LINE = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic [NIRQ-1:0]   irq_in,
    output logic              irq_out
);
    logic            sel_mask, sel_pend, sel_s0, sel_s1;
    logic [NIRQ-1:0] lvl;
    logic [DW-1:0]   mask_q, pend_q, sock0_q, sock1_q, plain_rd;
    logic            plain_hit;

    assign sel_mask = (bus_addr == ADDR_W'(OFS_MASK));
    assign sel_pend = (bus_addr == ADDR_W'(OFS_PEND));
    assign sel_s0   = (bus_addr == ADDR_W'(OFS_SOCK0));
    assign sel_s1   = (bus_addr == ADDR_W'(OFS_SOCK1));

    brd_irq_unit u_irq (
        .clk     (clk),
        .rst     (rst),
        .irq_in  (irq_in),
        .wr_mask (bus_we && sel_mask),
        .wr_pend (bus_we && sel_pend),
        .wdata   (bus_wdata),
        .level_q (lvl),
        .mask_q  (mask_q),
        .pend_q  (pend_q),
        .irq_q   (irq_out)
    );

    brd_sock_reg u_sock0 (
        .clk      (clk),
        .rst      (rst),
        .line_lvl (lvl[CD0_LINE]),
        .wr       (bus_we && sel_s0),
        .wdata    (bus_wdata[SOCK_WRB-1:0]),
        .q        (sock0_q)
    );

    brd_sock_reg u_sock1 (
        .clk      (clk),
        .rst      (rst),
        .line_lvl (lvl[CD1_LINE]),
        .wr       (bus_we && sel_s1),
        .wdata    (bus_wdata[SOCK_WRB-1:0]),
        .q        (sock1_q)
    );

    brd_plain_regs #(.ADDR_W(ADDR_W)) u_plain (
        .clk   (clk),
        .rst   (rst),
        .we    (bus_we),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .rdata (plain_rd),
        .hit   (plain_hit)
    );

    always_comb begin
        if (plain_hit)     bus_rdata = plain_rd;
        else if (sel_mask) bus_rdata = mask_q;
        else if (sel_pend) bus_rdata = pend_q;
        else if (sel_s0)   bus_rdata = sock0_q;
        else if (sel_s1)   bus_rdata = sock1_q;
        else               bus_rdata = '0;
    end
endmodule

// File: rtl/brd_ctl_regs_chk.sv
module brd_ctl_regs_chk
    import brd_regs_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int CD0_LINE = 9,
    parameter int CD1_LINE = 13
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [DW-1:0]     bus_wdata,
    input logic              irq_out,
    input logic [NIRQ-1:0]   lvl,
    input logic [DW-1:0]     mask_q,
    input logic [DW-1:0]     pend_q,
    input logic [DW-1:0]     sock0_q,
    input logic [DW-1:0]     sock1_q
);
    logic wr_pend;
    assign wr_pend = bus_we && (bus_addr == ADDR_W'(OFS_PEND));

    // R8: registered summary tracks the stored words
    a_r8_summary: assert property (@(posedge clk) disable iff (rst)
        irq_out == |(pend_q & mask_q));

    // R6: pending bits fall only through a bus write
    a_r6_no_self_clear: assert property (@(posedge clk) disable iff (rst)
        (|($past(pend_q) & ~pend_q)) |-> $past(wr_pend));

    // R6: enabled high levels are latched unless a bus write intervenes
    a_r6_latch: assert property (@(posedge clk) disable iff (rst)
        !$past(wr_pend) |->
        ((pend_q[NIRQ-1:0] & $past(lvl & mask_q[NIRQ-1:0])) == $past(lvl & mask_q[NIRQ-1:0])));

    // R7: a bus write to pending wins
    a_r7_write_wins: assert property (@(posedge clk) disable iff (rst)
        $past(wr_pend) |-> pend_q == ($past(bus_wdata) & IRQ_WMASK));

    // R9: card-absent flags are the inverted sampled levels
    a_r9_cd0: assert property (@(posedge clk) disable iff (rst)
        sock0_q[CD_BIT] == !$past(lvl[CD0_LINE]));
    a_r9_cd1: assert property (@(posedge clk) disable iff (rst)
        sock1_q[CD_BIT] == !$past(lvl[CD1_LINE]));

    // R10: socket bits above the card flag never move
    a_r10_sock_upper: assert property (@(posedge clk) disable iff (rst)
        (sock0_q[DW-1:CD_BIT+1] == SOCK_RST[DW-1:CD_BIT+1]) &&
        (sock1_q[DW-1:CD_BIT+1] == SOCK_RST[DW-1:CD_BIT+1]));
endmodule

bind brd_ctl_regs brd_ctl_regs_chk #(
    .ADDR_W(ADDR_W), .CD0_LINE(CD0_LINE), .CD1_LINE(CD1_LINE)
) u_chk (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .irq_out(irq_out), .lvl(lvl),
    .mask_q(mask_q), .pend_q(pend_q), .sock0_q(sock0_q), .sock1_q(sock1_q)
);

// File: tb/tb_brd_ctl_regs.sv
module tb_brd_ctl_regs;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] WM = 32'h000F_EEFF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] irq_in = '0;
    logic        irq_out;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    brd_ctl_regs dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_in(irq_in), .irq_out(irq_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // bench model
    logic [31:0] m_plain [8];
    logic [15:0] m_lvl;
    logic [31:0] m_mask, m_pend, m_s0, m_s1;
    logic        m_irq;

    function automatic int plain_idx(logic [7:0] a);
        case (a)
            8'h10: return 0; 8'h14: return 1; 8'h40: return 2; 8'h60: return 3;
            8'h80: return 4; 8'h84: return 5; 8'h88: return 6; 8'h90: return 7;
            default: return -1;
        endcase
    endfunction

    function automatic logic [31:0] m_read(logic [7:0] a);
        int k = plain_idx(a);
        if (k >= 0) return m_plain[k];
        case (a)
            8'hC0: return m_mask;
            8'hD0: return m_pend;
            8'hE0: return m_s0;
            8'hE4: return m_s1;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(logic [7:0] a);
        if (plain_idx(a) >= 0) return "R2";
        case (a)
            8'hC0: return "R4";
            8'hD0: return "R5/R6/R7";
            8'hE0, 8'hE4: return "R9/R10";
            default: return "R3";
        endcase
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 8; i++) m_plain[i] = '0;
        m_lvl = '0; m_mask = '0; m_pend = '0; m_irq = 1'b0;
        m_s0 = 32'h420; m_s1 = 32'h420;
    endtask

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    // one bus cycle: drive at negedge, check reads, clock, update model
    task automatic step(logic [7:0] a, logic w, logic [31:0] wd, logic [15:0] irq,
                        string tag = "");
        logic [31:0] n_pend, n_mask, n_s0, n_s1;
        int k;
        @(negedge clk);
        bus_addr = a; bus_we = w; bus_wdata = wd; irq_in = irq;
        #1;
        if (!w) check((tag == "") ? tag_of(a) : tag, bus_rdata, m_read(a));
        check("R8", {31'h0, irq_out}, {31'h0, m_irq});
        n_pend = m_pend | ({16'h0, m_lvl} & m_mask);
        n_mask = m_mask;
        n_s0 = m_s0; n_s1 = m_s1;
        n_s0[5] = ~m_lvl[9];
        n_s1[5] = ~m_lvl[13];
        if (w) begin
            k = plain_idx(a);
            if (k >= 0) m_plain[k] = wd;
            if (a == 8'hC0) n_mask = wd & WM;
            if (a == 8'hD0) n_pend = wd & WM;
            if (a == 8'hE0) n_s0[4:0] = wd[4:0];
            if (a == 8'hE4) n_s1[4:0] = wd[4:0];
        end
        @(posedge clk);
        #1;
        m_lvl = irq; m_pend = n_pend; m_mask = n_mask; m_s0 = n_s0; m_s1 = n_s1;
        m_irq = |(n_pend & n_mask);
    endtask

    localparam logic [7:0] ADDRS [14] = '{8'h10, 8'h14, 8'h40, 8'h60, 8'h80, 8'h84,
        8'h88, 8'h90, 8'hC0, 8'hD0, 8'hE0, 8'hE4, 8'h00, 8'hFC};

    initial begin
        model_reset();
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1: reset values
        for (int i = 0; i < 14; i++) step(ADDRS[i], 1'b0, '0, '0, "R1");

        // R2: plain words full width
        step(8'h40, 1'b1, 32'hDEAD_BEEF, '0);
        step(8'h40, 1'b0, '0, '0, "R2");
        // R3: unmapped write has no effect, reads zero
        step(8'h44, 1'b1, 32'hFFFF_FFFF, '0);
        step(8'h44, 1'b0, '0, '0, "R3");
        step(8'h40, 1'b0, '0, '0, "R3");
        // R4 / R5: write masks
        step(8'hC0, 1'b1, 32'hFFFF_FFFF, '0);
        step(8'hC0, 1'b0, '0, '0, "R4");
        step(8'hD0, 1'b1, 32'hFFFF_FFFF, '0);
        step(8'hD0, 1'b0, '0, '0, "R5");
        step(8'hD0, 1'b1, 32'h0, '0);
        step(8'hD0, 1'b0, '0, '0, "R5");
        // R6: enabled line latches, unmasked line 8 does not, falling keeps it
        step(8'hD0, 1'b0, '0, 16'h0108, "R6");
        step(8'hD0, 1'b0, '0, 16'h0108, "R6");
        step(8'hD0, 1'b0, '0, 16'h0000, "R6");
        step(8'hD0, 1'b0, '0, 16'h0000, "R6");
        // R7: write beats a same-edge latch
        step(8'hD0, 1'b1, 32'h0, 16'h0010);
        step(8'hD0, 1'b1, 32'h0, 16'h0010);
        step(8'hD0, 1'b0, '0, 16'h0010, "R7");
        // R9: card detect on lines 9 and 13
        step(8'hE0, 1'b0, '0, 16'h0200, "R9");
        step(8'hE0, 1'b0, '0, 16'h0200, "R9");
        step(8'hE0, 1'b0, '0, 16'h0200, "R9");
        step(8'hE4, 1'b0, '0, 16'h2000, "R9");
        step(8'hE4, 1'b0, '0, 16'h2000, "R9");
        step(8'hE0, 1'b0, '0, 16'h2000, "R9");
        // R10: only low five bits of socket words writable
        step(8'hE0, 1'b1, 32'hFFFF_FFFF, 16'h0);
        step(8'hE0, 1'b0, '0, 16'h0, "R10");
        step(8'hE4, 1'b1, 32'h0000_0000, 16'h0);
        step(8'hE4, 1'b0, '0, 16'h0, "R10");

        // random traffic
        begin
            logic [15:0] irq_r = '0;
            for (int n = 0; n < 3000; n++) begin
                logic [7:0] a;
                logic       w;
                if ($urandom_range(0, 3) == 0) irq_r = 16'($urandom);
                a = ($urandom_range(0, 9) == 0) ? 8'($urandom) : ADDRS[$urandom_range(0, 13)];
                w = $urandom_range(0, 2) == 0;
                step(a, w, $urandom, irq_r);
            end
        end
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                errors++; checks++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule